// File: doc/BRIEF.md
# Switch-and-button four-function calculator

This block turns a bank of eight slide switches into two 4-bit unsigned operands and, depending on which of four push buttons is held, forms their sum, their difference, their product or their quotient. The chosen result is shown twice: as an 8-bit binary value on a row of eight LEDs, and as a decimal number on a four-digit seven-segment display. The display is multiplexed, so only one digit is driven at a time, and a free-running counter steps through the digits in turn.

The difference is shown as a magnitude. A minus sign appears on the leftmost digit when the first operand is the smaller one. The quotient comes from a small sequential unit that subtracts the divisor over and over and counts the steps; it restarts whenever an operand changes, and the outputs keep the last finished quotient while it runs. A zero divisor never starts that unit: the LEDs go fully lit and the display shows an error letter. Switches and buttons pass through one register before use. There is no handshake anywhere: the inputs are level controls and the outputs are continuous drives, so no back-pressure rules apply.

Top module: `calc_top`

## Requirements
- R1: The first operand is switches [3:0] and the second is switches [7:4], both unsigned. With button code 0001 (only button 0 held), the LEDs show the 8-bit sum.
- R2: With button code 0010, the LEDs show the absolute difference of the two operands.
- R3: Digit 3 shows the minus glyph (8'hFE) only while button code 0010 is held and the first operand is smaller than the second. In every other case it is blank (8'hFF).
- R4: With button code 0100, the LEDs show the 8-bit product.
- R5: With button code 1000 and a nonzero second operand, the LEDs show the integer quotient of the first operand divided by the second, formed by repeated subtraction. It is correct no later than 19 clock edges after an input change. Between 2 and 18 edges after the change, the outputs show either the previous finished quotient or the new one, and nothing else.
- R6: With button code 1000 and the second operand zero, the LEDs read 8'hFF, digit 0 shows the error glyph 8'hB0, digits 1 to 3 are blank, and the held quotient is left unchanged.
- R7: With any button code that is not one-hot (including 0000), the LEDs mirror the eight switches and all four digits are blank.
- R8: For a valid result, digit 0 shows the units, digit 1 the tens and digit 2 the hundreds. Leading zeros are blank, and the units digit is always shown. Segment bytes are active low with bit 7 = dp, bit 6 = a through bit 0 = g. The digit codes for 0 to 9 are 81, CF, 92, 86, CC, A4, A0, 8F, 80, 84 (hex).
- R9: Exactly one digit enable is low at a time. Digit k is enabled by the pattern with bit k low. The active digit equals bits [SCAN_LSB+1:SCAN_LSB] of a counter that is cleared by reset and advances once per clock.
- R10: While reset is held, the LEDs read 0, all segments are off (8'hFF), and digit 0 is enabled.
- R11: Outside division, a change on the switches or buttons reaches the LEDs and the segments exactly 2 clock edges later. After only 1 edge, the outputs still show the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_i | input | 8 | Slide switches: [3:0] first operand, [7:4] second operand |
| btn_i | input | 4 | Push buttons, one-hot operation select |
| led_o | output | 8 | Binary result, or switch mirror when idle |
| seg_o | output | 8 | Active-low segments of the enabled digit (dp,a..g) |
| an_o | output | 4 | Active-low, one-hot digit enables |

## Verification
The bench sweeps every switch setting under each single button and under several multi-button codes. It checks every clock against a behavioural model that accepts only the previous result, the held quotient or the new result, each in the cycle where the requirements allow it. A quotient that shows partial counts while the divider is busy, or a divider that starts on a zero divisor, produces values outside that accepted set. A sign taken from the wrong comparison shows a minus sign where none belongs. Zeros blanked wrongly, such as a tens zero dropped from 105 or a lone units zero hidden, show up on the scanned digits. An extra or missing pipeline stage breaks the exact two-edge timing.

// File: rtl/calc_pkg.sv
package calc_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_ADD,
    OP_SUB,
    OP_MUL,
    OP_DIV
  } calc_op_e;

  localparam logic [7:0] SEG_BLANK = 8'hFF;
  localparam logic [7:0] SEG_MINUS = 8'hFE;
  localparam logic [7:0] SEG_ERR   = 8'hB0;

  // Active-low glyph for one decimal digit, bit 7 = dp, bit 6 = a .. bit 0 = g.
  function automatic logic [7:0] seg_of(input logic [3:0] d);
    logic [7:0] s;
    case (d)
      4'd0:    s = 8'h81;
      4'd1:    s = 8'hCF;
      4'd2:    s = 8'h92;
      4'd3:    s = 8'h86;
      4'd4:    s = 8'hCC;
      4'd5:    s = 8'hA4;
      4'd6:    s = 8'hA0;
      4'd7:    s = 8'h8F;
      4'd8:    s = 8'h80;
      4'd9:    s = 8'h84;
      default: s = SEG_BLANK;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/calc_div_iter.sv
module calc_div_iter #(
  parameter int OP_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] dividend_i,
  input  logic [OP_W-1:0] divisor_i,
  output logic [OP_W-1:0] quot_o
);

  localparam int LEN_W = OP_W + 2;

  logic [OP_W-1:0] lat_a_q, lat_b_q, rem_q, cnt_q, quot_q;
  logic            busy_q;
  logic            in_chg;
  logic            done;

  assign in_chg = (dividend_i != lat_a_q) || (divisor_i != lat_b_q);
  assign done   = busy_q && !in_chg && (rem_q < lat_b_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_a_q <= '0;
      lat_b_q <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      quot_q  <= '0;
      busy_q  <= 1'b0;
    end else if (in_chg) begin
      lat_a_q <= dividend_i;
      lat_b_q <= divisor_i;
      rem_q   <= dividend_i;
      cnt_q   <= '0;
      busy_q  <= (divisor_i != '0);
    end else if (busy_q) begin
      if (rem_q >= lat_b_q) begin
        rem_q <= rem_q - lat_b_q;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        quot_q <= cnt_q;
        busy_q <= 1'b0;
      end
    end
  end

  assign quot_o = quot_q;

  // checker: length of a busy run
  logic [LEN_W-1:0] run_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_len_q <= '0;
    else if (!busy_q)  run_len_q <= '0;
    else if (in_chg)   run_len_q <= '0;
    else               run_len_q <= run_len_q + 1'b1;
  end

  p_run_bounded_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_len_q <= LEN_W'(2**OP_W));

  p_quot_exact_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> ((2*OP_W)'(quot_o) * (2*OP_W)'(lat_b_q) <= (2*OP_W)'(lat_a_q)) &&
             ((2*OP_W)'(lat_a_q) < ((2*OP_W)'(quot_o) + 1) * (2*OP_W)'(lat_b_q)));

  p_quot_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(quot_o));

  p_zero_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (lat_b_q != '0));

endmodule

// File: rtl/calc_bin2bcd.sv
module calc_bin2bcd #(
  parameter int IN_W  = 8,
  parameter int N_DIG = 3
) (
  input  logic [IN_W-1:0]    bin_i,
  output logic [4*N_DIG-1:0] bcd_o
);

  localparam int SH_W = IN_W + 4 * N_DIG;

  logic [SH_W-1:0] sh;

  // shift-and-add-three conversion
  always_comb begin
    sh = '0;
    sh[IN_W-1:0] = bin_i;
    for (int i = 0; i < IN_W; i++) begin
      for (int d = 0; d < N_DIG; d++) begin
        if (sh[IN_W+4*d +: 4] >= 4'd5) sh[IN_W+4*d +: 4] = sh[IN_W+4*d +: 4] + 4'd3;
      end
      sh = sh << 1;
    end
    bcd_o = sh[IN_W +: 4*N_DIG];
  end

endmodule

// File: rtl/calc_scan.sv
module calc_scan #(
  parameter int SCAN_LSB = 15,
  parameter int N_DIG    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  output logic [$clog2(N_DIG)-1:0] sel_o,
  output logic [N_DIG-1:0]         an_o
);

  localparam int SEL_W = $clog2(N_DIG);
  localparam int CNT_W = SCAN_LSB + SEL_W;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign sel_o = cnt_q[CNT_W-1 -: SEL_W];

  for (genvar g = 0; g < N_DIG; g++) begin : g_an
    assign an_o[g] = (sel_o != SEL_W'(g));
  end

  p_one_digit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~an_o) == 1);

  p_step_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_o) |-> (sel_o == $past(sel_o) + 1'b1));

endmodule

// File: rtl/calc_top.sv
module calc_top
  import calc_pkg::*;
#(
  parameter int OP_W     = 4,
  parameter int SCAN_LSB = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [7:0]   sw_i,
  input  logic [3:0]   btn_i,
  output logic [7:0]   led_o,
  output logic [7:0]   seg_o,
  output logic [3:0]   an_o
);

  localparam int SW_W  = 2 * OP_W;
  localparam int RES_W = 2 * OP_W;
  localparam int N_DIG = 4;
  localparam int N_BCD = 3;
  localparam int SEL_W = $clog2(N_DIG);

  logic [SW_W-1:0]  sw_q;
  logic [3:0]       btn_q;
  logic [OP_W-1:0]  opa, opb, diff, quot;
  logic [RES_W-1:0] sum, prod, res_val;
  logic             neg, div_zero;
  calc_op_e         op;
  logic [4*N_BCD-1:0] bcd;
  logic [3:0]       hund, tens, units;
  logic [N_DIG-1:0][7:0] glyph_d, glyph_q;
  logic [RES_W-1:0] led_d, led_q;
  logic [SEL_W-1:0] sel;

  // input sampling
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= '0;
      btn_q <= '0;
    end else begin
      sw_q  <= sw_i;
      btn_q <= btn_i;
    end
  end

  assign opa = sw_q[OP_W-1:0];
  assign opb = sw_q[SW_W-1:OP_W];

  always_comb begin
    case (btn_q)
      4'b0001: op = OP_ADD;
      4'b0010: op = OP_SUB;
      4'b0100: op = OP_MUL;
      4'b1000: op = OP_DIV;
      default: op = OP_IDLE;
    endcase
  end

  assign sum  = RES_W'(opa) + RES_W'(opb);
  assign neg  = (opa < opb);
  assign diff = neg ? (opb - opa) : (opa - opb);
  assign prod = RES_W'(opa) * RES_W'(opb);

  calc_div_iter #(.OP_W(OP_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dividend_i (opa),
    .divisor_i  (opb),
    .quot_o     (quot)
  );

  assign div_zero = (op == OP_DIV) && (opb == '0);

  always_comb begin
    case (op)
      OP_ADD:  res_val = sum;
      OP_SUB:  res_val = RES_W'(diff);
      OP_MUL:  res_val = prod;
      OP_DIV:  res_val = RES_W'(quot);
      default: res_val = '0;
    endcase
  end

  calc_bin2bcd #(.IN_W(RES_W), .N_DIG(N_BCD)) u_bcd (
    .bin_i (res_val),
    .bcd_o (bcd)
  );

  assign units = bcd[3:0];
  assign tens  = bcd[7:4];
  assign hund  = bcd[11:8];

  always_comb begin
    glyph_d = {N_DIG{SEG_BLANK}};
    led_d   = res_val;
    if (op == OP_IDLE) begin
      led_d = sw_q;
    end else if (div_zero) begin
      led_d      = '1;
      glyph_d[0] = SEG_ERR;
    end else begin
      glyph_d[0] = seg_of(units);
      if (hund != '0 || tens != '0) glyph_d[1] = seg_of(tens);
      if (hund != '0)               glyph_d[2] = seg_of(hund);
      if (op == OP_SUB && neg)      glyph_d[3] = SEG_MINUS;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_q   <= '0;
      glyph_q <= {N_DIG{SEG_BLANK}};
    end else begin
      led_q   <= led_d;
      glyph_q <= glyph_d;
    end
  end

  calc_scan #(.SCAN_LSB(SCAN_LSB), .N_DIG(N_DIG)) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_o  (sel),
    .an_o   (an_o)
  );

  assign led_o = led_q;
  assign seg_o = glyph_q[sel];

  p_minus_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glyph_q[3] == SEG_MINUS) |-> $past(op == OP_SUB && opa < opb));

  p_err_pattern_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(div_zero) |-> (led_q == '1 && glyph_q[0] == SEG_ERR));

  p_idle_mirror_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(op == OP_IDLE) |-> (led_q == $past(sw_q) && glyph_q == {N_DIG{SEG_BLANK}}));

  p_bcd_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (units <= 4'd9) && (tens <= 4'd9) && (hund <= 4'd9));

endmodule

// File: tb/calc_top_bench.sv
module calc_top_bench;

  localparam int SL   = 2;
  localparam int HOLD = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sw = '0;
  logic [3:0] btn = '0;
  logic [7:0] led, seg;
  logic [3:0] an;

  always #4 clk = ~clk;

  calc_top #(.SCAN_LSB(SL)) u_calc_top (
    .clk_i (clk), .rst_ni (rst_n), .sw_i (sw), .btn_i (btn),
    .led_o (led), .seg_o (seg), .an_o (an)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, k = 1000, last_q = 0;
  bit finished = 0;
  logic [7:0] p_led, b_led, c_led;
  logic [3:0][7:0] p_g, b_g, c_g;

  function automatic logic [7:0] digit_glyph(input int d);
    case (d)
      0: return 8'h81; 1: return 8'hCF; 2: return 8'h92; 3: return 8'h86;
      4: return 8'hCC; 5: return 8'hA4; 6: return 8'hA0; 7: return 8'h8F;
      8: return 8'h80; default: return 8'h84;
    endcase
  endfunction

  task automatic model(input logic [7:0] s, input logic [3:0] b, input int q,
                       output logic [7:0] l, output logic [3:0][7:0] g);
    int a, o, v;
    a = s[3:0]; o = s[7:4];
    g = {4{8'hFF}};
    l = s;
    if (!(b == 1 || b == 2 || b == 4 || b == 8)) return;
    if (b == 8 && o == 0) begin
      l = 8'hFF; g[0] = 8'hB0; return;
    end
    case (b)
      1: v = a + o;
      2: v = (a >= o) ? a - o : o - a;
      4: v = a * o;
      default: v = q;
    endcase
    l = v[7:0];
    g[0] = digit_glyph(v % 10);
    if (v >= 10)  g[1] = digit_glyph((v / 10) % 10);
    if (v >= 100) g[2] = digit_glyph(v / 100);
    if (b == 2 && a < o) g[3] = 8'hFE;
  endtask

  function automatic string tag_of(input logic [7:0] s, input logic [3:0] b, input int d);
    if (k == 1) return "R11";
    case (b)
      1: return "R1";
      2: return (d == 3) ? "R3" : "R2";
      4: return "R4";
      8: return (s[7:4] == 0) ? "R6" : "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check_cycle();
    int d;
    bit ok;
    d = (cyc >> SL) & 3;
    n_cmp++;
    if (an !== ~(4'b1 << d)) begin
      n_bad++;
      $display("FAIL R9 digit enable actual=%b expected=%b", an, ~(4'b1 << d));
    end
    n_cmp++;
    if (k == 1) ok = (led === p_led) && (seg === p_g[d]);
    else begin
      ok = (led === c_led) && (seg === c_g[d]);
      if (btn == 8 && sw[7:4] != 0 && k < 19)
        ok = ok || ((led === b_led) && (seg === b_g[d]));
    end
    if (!ok) begin
      n_bad++;
      if (k == 1)
        $display("FAIL R11 led/seg actual=%h/%h expected=%h/%h", led, seg, p_led, p_g[d]);
      else if (led === c_led)
        $display("FAIL R8 %s digit %0d actual=%h expected=%h", tag_of(sw, btn, d), d, seg, c_g[d]);
      else
        $display("FAIL %s sw=%h btn=%b led/seg actual=%h/%h expected=%h/%h",
                 tag_of(sw, btn, d), sw, btn, led, seg, c_led, c_g[d]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    cyc++; k++;
    @(negedge clk);
    check_cycle();
  endtask

  task automatic apply(input logic [7:0] s, input logic [3:0] b);
    if (sw[7:4] != 0) last_q = sw[3:0] / sw[7:4];
    p_led = c_led; p_g = c_g;
    sw = s; btn = b;
    model(s, b, (s[7:4] != 0) ? s[3:0] / s[7:4] : last_q, c_led, c_g);
    model(s, b, last_q, b_led, b_g);
    k = 0;
    repeat (HOLD) step();
  endtask

  initial begin
    model(8'h00, 4'h0, 0, c_led, c_g);
    p_led = c_led; p_g = c_g;
    repeat (3) @(negedge clk);
    // R10: reset state
    n_cmp++;
    if (led !== 8'h00 || seg !== 8'hFF || an !== 4'b1110) begin
      n_bad++;
      $display("FAIL R10 reset led/seg/an actual=%h/%h/%b expected=00/ff/1110", led, seg, an);
    end
    rst_n = 1'b1;
    repeat (20) step();
    // R1, R2, R3, R4, R5, R6, R8 over every switch setting
    for (int b = 0; b < 4; b++) begin
      for (int s = 0; s < 256; s++) apply(8'(s), 4'(1 << b));
    end
    // R7: idle and non-one-hot codes
    for (int s = 0; s < 256; s += 5) apply(8'(s), 4'b0000);
    for (int s = 0; s < 256; s += 17) begin
      apply(8'(s), 4'b0011);
      apply(8'(s), 4'b1111);
      apply(8'(s), 4'b1010);
    end
    // R5 hold across a zero divisor, then back to a valid one (R6 leaves quotient)
    apply(8'h1F, 4'b1000);
    apply(8'h0F, 4'b1000);
    apply(8'h2E, 4'b1000);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R10 watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule